// File: doc/BRIEF.md
# Word Program Sequencer with Verify and Retry

This block is a host-side controller that writes a contiguous range of words into an electrically reprogrammable memory through its chip-enable, output-enable and write-enable bus. For every word it writes a program-setup command, then a second write that carries the target address and data, and then waits a fixed program-pulse interval. It then reads the word back to verify it. A mismatch starts another attempt on the same word, up to a fixed limit. A match earns the word one more programming attempt without a read-back, which adds retention margin. The sequencer then moves to the next address.

A job starts with a single-cycle `start` and runs with the first and last addresses held stable. The data to program comes from an external source port: the block presents an address and takes the returned word in the same cycle. The high programming voltage is requested through `hv_en`, which rises at the start of a job and falls at its end, and it only changes while the memory is deselected. At the end of the job `done` or `fail` pulses for one cycle. On failure `fail_addr` names the word that would not program.

Top module: `word_prog_seq`

## Requirements
- R1: After reset `hv_en`, `done`, `fail` and `mem_dq_oe` are 0, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `fail_addr` is 0.
- R2: `start` raises `hv_en`. `mem_ce_n` first goes low no sooner than HV_SETTLE cycles after `hv_en` rises. `hv_en` changes only in cycles where `mem_ce_n` and `mem_oe_n` are both 1, and it is 1 whenever `mem_ce_n` is 0.
- R3: Every programming attempt is a write of the setup word CMD_SETUP (default 16'h0040) followed by a write of the target address with the source data for that address. No data write happens without a setup write just before it.
- R4: In every bus write, `mem_ce_n` falls with address and data already driven. `mem_we_n` then goes low after T_SU cycles, stays low for T_WP cycles, and is followed by T_HD cycles of hold before `mem_ce_n` rises. Address and data stay stable for the whole cycle. A read keeps `mem_ce_n` and `mem_oe_n` low for T_RD cycles.
- R5: After each address/data write the bus stays idle (`mem_ce_n` high) for at least PULSE_CYC cycles.
- R6: After every attempt except the margin attempt, the word is read back at the same address. A read value that differs from the written data starts a new attempt on the same word.
- R7: If MAX_TRY (default 25) verify reads of one word all fail, `fail` pulses, `fail_addr` holds that address, no further words are written, and `hv_en` drops. A word that passes on attempt MAX_TRY does not fail.
- R8: Once a word verifies, exactly one more setup/data attempt is made on that word, with no verify read after it. A word that needs n attempts therefore receives n+1 data writes and n verify reads.
- R9: The attempt count starts from zero for every word. Two adjacent words that each need close to MAX_TRY attempts both pass.
- R10: Words are written in ascending address order from `first_addr` to `last_addr` inclusive, and first = last programs a single word. After the last word `done` pulses and `hv_en` drops.
- R11: `done` and `fail` are single-cycle pulses and never high together. `fail_addr` keeps its value until the next `start`, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle job start |
| first_addr | input | AW | First word address of the job |
| last_addr | input | AW | Last word address of the job |
| src_addr | output | AW | Address presented to the data source |
| src_data | input | DW | Word to program at `src_addr` (same cycle) |
| hv_en | output | 1 | Request for the high programming voltage |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | DW | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data read from the memory |
| done | output | 1 | One-cycle pulse: job completed |
| fail | output | 1 | One-cycle pulse: a word exhausted its attempts |
| fail_addr | output | AW | Address of the word that failed |

## Verification
A behavioural memory model gives each address a required number of attempts and returns corrupted data on read-back until that many data writes have reached the word. This lets the bench compute the exact number of writes and reads per word. Directed jobs cover a single word needing one attempt, a word needing exactly the attempt limit, two adjacent words each needing twenty attempts, and a range whose third word needs one attempt more than the limit. Together these separate a correct limit from an off-by-one, a per-word count from a cumulative one, and a stop on failure from a run that carries on. Random jobs with random ranges and attempt counts check the ordering, the margin attempt and the bus timing, which a monitor measures on every cycle.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HV, S_CMD, S_DAT, S_PUL, S_VFY, S_NXT, S_DONE, S_FAIL
  } seq_state_t;

  typedef enum logic [2:0] {
    B_IDLE, B_SU, B_WE, B_HD, B_RD
  } bus_phase_t;

  // true when the attempt just verified was the last one permitted
  function automatic logic tries_used_up(input int done_tries, input int limit);
    return (done_tries + 1) >= limit;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wps_timer.sv
module wps_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] value,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      run    <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= value;
        run <= (value != '0);
      end else if (run) begin
        if (cnt == TW'(1)) begin
          run    <= 1'b0;
          expire <= 1'b1;
        end
        cnt <= cnt - TW'(1);
      end
    end
  end

  // R5: the wait ends with a single-cycle event
  a_r5_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/wps_bus.sv
module wps_bus
  import wps_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int T_SU = 2,
  parameter int T_WP = 2,
  parameter int T_HD = 1,
  parameter int T_RD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] dq_in
);
  localparam int TMAX = max2(max2(T_SU, T_WP), max2(T_HD, T_RD));
  localparam int CW   = $clog2(TMAX + 1);

  bus_phase_t    ph;
  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          bus_idle;

  assign cnt_zero = (cnt == '0);
  assign bus_idle = (ph == B_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= B_IDLE;
      cnt   <= '0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      addr  <= '0;
      dout  <= '0;
      rdata <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (ph)
        B_IDLE: if (req) begin
          addr <= req_addr;
          ce_n <= 1'b0;
          if (req_rd) begin
            oe_n <= 1'b0;
            cnt  <= CW'(T_RD - 1);
            ph   <= B_RD;
          end else begin
            dout  <= req_data;
            dq_oe <= 1'b1;
            cnt   <= CW'(T_SU - 1);
            ph    <= B_SU;
          end
        end
        B_SU: if (cnt_zero) begin
          we_n <= 1'b0;
          cnt  <= CW'(T_WP - 1);
          ph   <= B_WE;
        end else cnt <= cnt - CW'(1);
        B_WE: if (cnt_zero) begin
          we_n <= 1'b1;
          cnt  <= CW'(T_HD - 1);
          ph   <= B_HD;
        end else cnt <= cnt - CW'(1);
        B_HD: if (cnt_zero) begin
          ce_n  <= 1'b1;
          dq_oe <= 1'b0;
          ack   <= 1'b1;
          ph    <= B_IDLE;
        end else cnt <= cnt - CW'(1);
        B_RD: if (cnt_zero) begin
          rdata <= dq_in;
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          ack   <= 1'b1;
          ph    <= B_IDLE;
        end else cnt <= cnt - CW'(1);
        default: ph <= B_IDLE;
      endcase
    end
  end

  a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe));
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr));
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dout));
  a_r4_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ce_n && oe_n && we_n));
  a_r4_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> bus_idle);

endmodule

// File: rtl/word_prog_seq.sv
module word_prog_seq
  import wps_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          PULSE_CYC = 2500,
  parameter int          HV_SETTLE = 200,
  parameter int          MAX_TRY   = 25,
  parameter int          T_SU      = 2,
  parameter int          T_WP      = 2,
  parameter int          T_HD      = 1,
  parameter int          T_RD      = 3,
  parameter logic [DW-1:0] CMD_SETUP = DW'(16'h0040)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic          hv_en,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int TW   = $clog2(max2(PULSE_CYC, HV_SETTLE) + 1);
  localparam int TRYW = $clog2(MAX_TRY + 1);

  seq_state_t      st;
  logic [AW-1:0]   cur;
  logic [TRYW-1:0] tries;
  logic            extra;
  logic [DW-1:0]   wdat_q;
  logic            req_q, bop_rd;
  logic [AW-1:0]   bop_addr;
  logic [DW-1:0]   bop_data;
  logic            tmr_load, tmr_exp;
  logic [TW-1:0]   tmr_val;
  logic            bus_ack;
  logic [DW-1:0]   bus_rdata;

  // named events for the assertions
  logic verify_pass, verify_miss, word_adv;
  assign verify_pass = (st == S_VFY) && bus_ack && (bus_rdata == wdat_q);
  assign verify_miss = (st == S_VFY) && bus_ack && (bus_rdata != wdat_q);
  assign word_adv    = (st == S_NXT) && (cur != last_addr);

  assign src_addr = cur;

  wps_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val), .expire(tmr_exp)
  );

  wps_bus #(.AW(AW), .DW(DW), .T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD), .T_RD(T_RD)) u_bus (
    .clk(clk), .rst_n(rst_n), .req(req_q), .req_rd(bop_rd), .req_addr(bop_addr),
    .req_data(bop_data), .ack(bus_ack), .rdata(bus_rdata), .ce_n(mem_ce_n),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe), .addr(mem_addr),
    .dout(mem_dq_out), .dq_in(mem_dq_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hv_en <= 1'b0; cur <= '0; tries <= '0; extra <= 1'b0;
      wdat_q <= '0; req_q <= 1'b0; bop_rd <= 1'b0; bop_addr <= '0; bop_data <= '0;
      tmr_load <= 1'b0; tmr_val <= '0; done <= 1'b0; fail <= 1'b0; fail_addr <= '0;
    end else begin
      req_q    <= 1'b0;
      tmr_load <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          hv_en     <= 1'b1;
          cur       <= first_addr;
          tries     <= '0;
          extra     <= 1'b0;
          fail_addr <= '0;
          tmr_load  <= 1'b1;
          tmr_val   <= TW'(HV_SETTLE);
          st        <= S_HV;
        end
        S_HV: if (tmr_exp) begin
          req_q <= 1'b1; bop_rd <= 1'b0; bop_addr <= cur; bop_data <= CMD_SETUP;
          st    <= S_CMD;
        end
        S_CMD: if (bus_ack) begin
          req_q <= 1'b1; bop_rd <= 1'b0; bop_addr <= cur; bop_data <= src_data;
          wdat_q <= src_data;
          st     <= S_DAT;
        end
        S_DAT: if (bus_ack) begin
          tmr_load <= 1'b1;
          tmr_val  <= TW'(PULSE_CYC);
          st       <= S_PUL;
        end
        S_PUL: if (tmr_exp) begin
          if (extra) st <= S_NXT;
          else begin
            req_q <= 1'b1; bop_rd <= 1'b1; bop_addr <= cur;
            st    <= S_VFY;
          end
        end
        S_VFY: if (bus_ack) begin
          if (verify_pass) begin
            extra <= 1'b1;
            req_q <= 1'b1; bop_rd <= 1'b0; bop_addr <= cur; bop_data <= CMD_SETUP;
            st    <= S_CMD;
          end else if (tries_used_up(int'(tries), MAX_TRY)) begin
            st <= S_FAIL;
          end else begin
            tries <= tries + TRYW'(1);
            req_q <= 1'b1; bop_rd <= 1'b0; bop_addr <= cur; bop_data <= CMD_SETUP;
            st    <= S_CMD;
          end
        end
        S_NXT: if (cur == last_addr) st <= S_DONE;
        else begin
          cur   <= cur + AW'(1);
          tries <= '0;
          extra <= 1'b0;
          req_q <= 1'b1; bop_rd <= 1'b0; bop_addr <= cur + AW'(1); bop_data <= CMD_SETUP;
          st    <= S_CMD;
        end
        S_DONE: begin hv_en <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        S_FAIL: begin hv_en <= 1'b0; fail <= 1'b1; fail_addr <= cur; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_hv_moves_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en != $past(hv_en)) |-> (mem_ce_n && mem_oe_n));
  a_r2_bus_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> hv_en);
  a_r4_no_read_while_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r7_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries) < MAX_TRY);
  a_r7_fail_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(verify_miss, 2));
  a_r9_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    word_adv |=> (tries == '0));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

endmodule

// File: tb/tb_word_prog_seq.sv
module tb_word_prog_seq;
  localparam int AW = 8, DW = 16;
  localparam int PULSE = 20, HVS = 6, MAXT = 25;
  localparam int TSU = 2, TWP = 3, THD = 1, TRD = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0, src_addr, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_dq_out, mem_dq_in;
  logic hv_en, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done, fail;

  always #5 clk = ~clk;

  word_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .HV_SETTLE(HVS), .MAX_TRY(MAXT),
    .T_SU(TSU), .T_WP(TWP), .T_HD(THD), .T_RD(TRD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .src_addr(src_addr), .src_data(src_data), .hv_en(hv_en), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .done(done), .fail(fail), .fail_addr(fail_addr));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] salt = 16'h3c5a;

  function automatic logic [DW-1:0] src_fn(input logic [AW-1:0] a, input logic [15:0] s);
    return (16'(a) * 16'h9e37) ^ s ^ {a, 8'h5a};
  endfunction
  assign src_data = src_fn(src_addr, salt);

  // memory model
  int need [256];
  int pulses [256];
  int verifies [256];
  logic [DW-1:0] stored [256];
  bit armed;
  int proto_err, tim_err, gap_err, hv_err, ord_err, done_cnt, fail_cnt;
  logic [AW-1:0] cur_a;

  always_comb begin
    if (!mem_ce_n && !mem_oe_n)
      mem_dq_in = (pulses[mem_addr] >= need[mem_addr]) ? stored[mem_addr]
                                                       : (stored[mem_addr] ^ 16'h0101);
    else
      mem_dq_in = '0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bus monitor, sampled on the falling edge
  int cyc = 0, hv_t = 0, wr_end_t = 0, su_c, wl_c, hd_c, rd_c;
  bit prev_ce = 1, prev_hv = 0, last_data = 0;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (done) done_cnt++;
      if (fail) fail_cnt++;
      if (hv_en != prev_hv) begin
        if (!(mem_ce_n && mem_oe_n)) hv_err++;
        if (hv_en) hv_t = cyc;
      end
      if (prev_ce && !mem_ce_n) begin
        if (!hv_en || (cyc - hv_t) < HVS) hv_err++;
        if (last_data && (cyc - wr_end_t) < PULSE) gap_err++;
        su_c = 0; wl_c = 0; hd_c = 0; rd_c = 0;
        w_addr = mem_addr; w_data = mem_dq_out;
      end
      if (!mem_ce_n) begin
        if (mem_addr != w_addr) tim_err++;
        if (!mem_oe_n) rd_c++;
        else begin
          if (!mem_dq_oe || mem_dq_out != w_data) tim_err++;
          if (!mem_we_n) wl_c++;
          else if (wl_c == 0) su_c++;
          else hd_c++;
        end
      end
      if (!prev_ce && mem_ce_n) begin
        if (rd_c > 0) begin
          if (rd_c != TRD || wl_c != 0) tim_err++;
          verifies[w_addr]++;
          last_data = 0;
        end else begin
          if (su_c != TSU || wl_c != TWP || hd_c != THD) tim_err++;
          if (!armed) begin
            if (w_data == 16'h0040) armed = 1; else proto_err++;
          end else begin
            armed = 0;
            if (w_data != src_fn(w_addr, salt)) proto_err++;
            if (w_addr != cur_a) begin
              if (w_addr != cur_a + 8'd1) ord_err++;
              cur_a = w_addr;
            end
            pulses[w_addr]++;
            stored[w_addr] = w_data;
            wr_end_t = cyc;
            last_data = 1;
          end
        end
      end
      prev_ce = mem_ce_n;
      prev_hv = hv_en;
    end
  end

  task automatic run_job(input int fa, input int la);
    int wait_c;
    bit exp_fail;
    int fa_exp;
    for (int i = 0; i < 256; i++) begin pulses[i] = 0; verifies[i] = 0; stored[i] = '0; end
    armed = 0; proto_err = 0; tim_err = 0; gap_err = 0; hv_err = 0; ord_err = 0;
    done_cnt = 0; fail_cnt = 0; cur_a = AW'(fa - 1); last_data = 0;
    @(negedge clk);
    first_addr = AW'(fa); last_addr = AW'(la); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(hv_en == 1'b1, "R2", "hv_en after start", int'(hv_en), 1);
    chk(fail_addr == '0, "R11", "fail_addr cleared by start", int'(fail_addr), 0);
    wait_c = 0;
    while (done_cnt + fail_cnt == 0 && wait_c < 60000) begin @(negedge clk); wait_c++; end
    chk(wait_c < 60000, "R10", "job finished", wait_c, 0);
    repeat (3) @(negedge clk);
    exp_fail = 0; fa_exp = 0;
    for (int a = fa; a <= la; a++) begin
      if (need[a] > MAXT) begin
        exp_fail = 1; fa_exp = a;
        chk(pulses[a] == MAXT, "R7", "writes on failing word", pulses[a], MAXT);
        chk(verifies[a] == MAXT, "R7", "reads on failing word", verifies[a], MAXT);
        if (a < la) chk(pulses[a+1] == 0, "R7", "word after failure untouched", pulses[a+1], 0);
        break;
      end
      chk(pulses[a] == need[a] + 1, "R8", $sformatf("data writes at %0d", a), pulses[a], need[a] + 1);
      chk(verifies[a] == need[a], "R6", $sformatf("verify reads at %0d", a), verifies[a], need[a]);
    end
    chk(done_cnt == (exp_fail ? 0 : 1), "R10", "done pulses", done_cnt, exp_fail ? 0 : 1);
    chk(fail_cnt == (exp_fail ? 1 : 0), "R7", "fail pulses", fail_cnt, exp_fail ? 1 : 0);
    chk(int'(fail_addr) == fa_exp, "R7", "fail_addr", int'(fail_addr), fa_exp);
    chk(hv_en == 1'b0, "R10", "hv_en dropped at end", int'(hv_en), 0);
    chk(hv_err == 0, "R2", "voltage sequencing errors", hv_err, 0);
    chk(proto_err == 0, "R3", "setup/data protocol errors", proto_err, 0);
    chk(tim_err == 0, "R4", "bus timing errors", tim_err, 0);
    chk(gap_err == 0, "R5", "pulse interval errors", gap_err, 0);
    chk(ord_err == 0, "R10", "address order errors", ord_err, 0);
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 256; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hv_en == 0 && done == 0 && fail == 0 && mem_dq_oe == 0, "R1", "reset outputs low", 0, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "reset strobes high", int'(mem_ce_n), 1);
    chk(fail_addr == '0, "R1", "reset fail_addr", int'(fail_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 single word, one attempt
    need[5] = 1;
    run_job(5, 5);
    // R6 R8 small range, varied attempt counts
    for (int a = 16; a <= 23; a++) need[a] = 1 + int'($urandom_range(4));
    run_job(16, 23);
    // R7 boundary pass at limit, R9 per-word count
    need[40] = MAXT; need[41] = 20; need[42] = 20;
    run_job(40, 42);
    // R7 failure one beyond the limit mid-range
    need[60] = 2; need[61] = 3; need[62] = MAXT + 1; need[63] = 1;
    run_job(60, 63);
    // R11 fail_addr holds while idle
    repeat (50) @(negedge clk);
    chk(fail_addr == 8'd62, "R11", "fail_addr held", int'(fail_addr), 62);
    chk(done == 0 && fail == 0, "R11", "no pulses while idle", int'(done) + int'(fail), 0);
    salt = 16'ha5c3;
    run_job(70, 71);
    // random jobs
    for (int r = 0; r < 5; r++) begin
      int fa, len;
      fa  = 100 + int'($urandom_range(100));
      len = int'($urandom_range(5));
      salt = 16'($urandom);
      for (int a = fa; a <= fa + len; a++)
        need[a] = ($urandom_range(7) == 0) ? MAXT + 1 : 1 + int'($urandom_range(5));
      run_job(fa, fa + len);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule